// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count, and can also take an index (once-per-revolution) pulse. Each of the three pins passes through a two-stage synchroniser and an optional digital glitch filter with a programmable length. The counter then works in x4 mode: every single-phase transition moves the count by one, and the order in which the phases change gives the direction.

Software drives the block through a simple single-cycle register port. It sets the polarity of each pin, swaps the roles of the two phases, chooses how the count returns to zero, and sets a wrap limit. One reset scheme uses an index edge that is qualified by a chosen pair of phase levels. The other lets the count simply wrap at the limit. While the counter runs, all configuration except the run bit is frozen.

Wrap, index-reset and direction-reversal events are recorded in write-one-to-clear status bits. A single interrupt line combines the status bits that are not masked.

Top module: `quad_enc_ctr`

## Requirements
- R1: After reset the control word reads 0, the count 0, the filter length 0, the ceiling all ones, the status 0, the mask 0x3F, and `irq` is low.
- R2: Register offsets are control 0x00, filter length 0x04, count 0x08, ceiling 0x0C, status 0x20 and mask 0x24. While running, each single transition of the effective phases changes the count by one: up when the effective {A,B} levels step through 00, 10, 11, 01 (A leads), and down for the reverse order.
- R3: Control bits 2 and 3 set the polarity of pins A and B, and bit 4 sets the polarity of the index pin: 1 passes the pin through and 0 inverts it. Bit 5 swaps A and B after the polarity step. Setting the swap bit, or inverting exactly one phase, reverses the counting direction.
- R4: Counting up from a count equal to the ceiling gives 0 and sets status bit 2. Counting down from 0 gives the ceiling and sets status bit 1.
- R5: With control bit 8 at 0, an index edge resets the count to 0 when the effective {A,B} levels equal the 2-bit gate code in control bits 10:9 (code 0 is A low, B low; 1 is A low, B high; 2 is A high, B low; 3 is A high, B high). The edge is rising when bit 4 is 1 and falling when it is 0. The reset sets status bit 2 if the last step was up and bit 1 otherwise. An index edge with any other phase levels has no effect.
- R6: With control bit 8 at 1, the index pin has no effect on the count.
- R7: When control bit 1 is 1 and the filter length N (21 bits) is not zero, a pin level is accepted only after it has held for N consecutive clocks, so shorter pulses are dropped. In every other case the filter is bypassed.
- R8: While control bit 0 (run) is 1, writes to the filter length, to the ceiling and to every control field except bit 0 are ignored. Bit 0 itself stays writable.
- R9: The count is read-only and does not change while run is 0.
- R10: A step whose direction differs from the previous step sets status bit 3. No status bit becomes set while run is 0.
- R11: Writing 1 to a status bit clears it. Status bits 0, 4 and 5 always read 0. `irq` is the OR of the status bits whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| enc_a | input | 1 | Encoder phase A pin, asynchronous |
| enc_b | input | 1 | Encoder phase B pin, asynchronous |
| enc_idx | input | 1 | Encoder index pin, asynchronous |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
The assertions assume that reset is applied before the first use. They also assume that a register write lasts exactly one cycle, so that freezing the configuration while running and holding the count while stopped can be judged edge by edge. The single-step bound on the count assumes the two phases never change in the same sampled cycle, because a double change is discarded rather than counted. The stimulus meets all of these conditions:
- Each phase level is held well beyond the synchroniser and filter latency, and the phases move strictly one at a time.
- Polarity and swap change only while the counter is stopped, and the bench waits before restarting it.
- The count is cleared by an index reset before a smaller ceiling takes effect.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // register byte offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_FILT  = 'h04;
    localparam int OFS_COUNT = 'h08;
    localparam int OFS_CEIL  = 'h0C;
    localparam int OFS_STAT  = 'h20;
    localparam int OFS_MASK  = 'h24;

    // control word bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_FLT  = 1;
    localparam int CB_POLA = 2;
    localparam int CB_POLB = 3;
    localparam int CB_POLI = 4;
    localparam int CB_SWAP = 5;
    localparam int CB_MODE = 8;
    localparam int CB_GATE = 9;

    // status bits
    localparam int STAT_W      = 6;
    localparam int ST_WRAP_DN  = 1;
    localparam int ST_WRAP_UP  = 2;
    localparam int ST_TURN     = 3;

    typedef struct packed {
        logic [1:0] gate;
        logic       rst_on_ceil;
        logic       swap;
        logic       pol_idx;
        logic       pol_b;
        logic       pol_a;
        logic       flt_en;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic up;
        logic down;
        logic turn;
    } cnt_evt_t;

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CB_RUN]          = c.run;
        w[CB_FLT]          = c.flt_en;
        w[CB_POLA]         = c.pol_a;
        w[CB_POLB]         = c.pol_b;
        w[CB_POLI]         = c.pol_idx;
        w[CB_SWAP]         = c.swap;
        w[CB_MODE]         = c.rst_on_ceil;
        w[CB_GATE+1:CB_GATE] = c.gate;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.run         = w[CB_RUN];
        c.flt_en      = w[CB_FLT];
        c.pol_a       = w[CB_POLA];
        c.pol_b       = w[CB_POLB];
        c.pol_idx     = w[CB_POLI];
        c.swap        = w[CB_SWAP];
        c.rst_on_ceil = w[CB_MODE];
        c.gate        = w[CB_GATE+1:CB_GATE];
        return c;
    endfunction

endpackage

// File: rtl/qenc_input_cond.sv
module qenc_input_cond #(
    parameter int FLT_W       = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             flt_on,
    input  logic [FLT_W-1:0] flt_len,
    output logic             level
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   level;
        logic [FLT_W-1:0]       run;
    } cond_t;

    cond_t cond_d, cond_q;
    logic  sampled;

    assign sampled = cond_q.sync[SYNC_STAGES-1];

    always_comb begin
        cond_d      = cond_q;
        cond_d.sync = {cond_q.sync[SYNC_STAGES-2:0], pin};
        if (!flt_on) begin
            cond_d.level = sampled;
            cond_d.run   = '0;
        end else if (sampled == cond_q.level) begin
            // candidate level fell back: restart the stability window
            cond_d.run = '0;
        end else if (cond_q.run + 1'b1 >= flt_len) begin
            cond_d.level = sampled;
            cond_d.run   = '0;
        end else begin
            cond_d.run = cond_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_d;
    end

    assign level = cond_q.level;
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    input  logic b_in,
    input  logic swap,
    output logic a_eff,
    output logic b_eff,
    output logic step,
    output logic up
);
    typedef struct packed {
        logic a;
        logic b;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        a_eff    = swap ? b_in : a_in;
        b_eff    = swap ? a_in : b_in;
        prev_d.a = a_eff;
        prev_d.b = b_eff;
        // exactly one phase moved; a double move carries no direction
        step     = (a_eff ^ prev_q.a) != (b_eff ^ prev_q.b);
        up       = a_eff ^ prev_q.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/qenc_position.sv
module qenc_position
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             up,
    input  logic             idx_hit,
    input  logic [CNT_W-1:0] ceil,
    output logic [CNT_W-1:0] count,
    output cnt_evt_t         evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        evt   = '0;
        if (run) begin
            if (step) begin
                pos_d.dir_up = up;
                evt.turn     = (up != pos_q.dir_up);
            end
            if (idx_hit) begin
                pos_d.cnt = '0;
                evt.up    = pos_q.dir_up;
                evt.down  = !pos_q.dir_up;
            end else if (step && up) begin
                if (pos_q.cnt == ceil) begin
                    pos_d.cnt = '0;
                    evt.up    = 1'b1;
                end else begin
                    pos_d.cnt = pos_q.cnt + 1'b1;
                end
            end else if (step) begin
                if (pos_q.cnt == '0) begin
                    pos_d.cnt = ceil;
                    evt.down  = 1'b1;
                end else begin
                    pos_d.cnt = pos_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q.cnt    <= '0;
            pos_q.dir_up <= 1'b1;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign count = pos_q.cnt;
endmodule

// File: rtl/quad_enc_ctr.sv
module quad_enc_ctr
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int FLT_W       = 21,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_idx,
    output logic              irq
);
    localparam int N_IN   = 3;
    localparam int IN_A   = 0;
    localparam int IN_B   = 1;
    localparam int IN_IDX = 2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [FLT_W-1:0]  filt;
        logic [CNT_W-1:0]  ceil;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] mask;
        logic              idx_prev;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              flt_on;
    logic [N_IN-1:0]   raw_pins;
    logic [N_IN-1:0]   clean;
    logic [N_IN-1:0]   pol_mask;
    logic [N_IN-1:0]   aligned;
    logic              a_eff, b_eff, step, up;
    logic              gate_ok, idx_hit;
    logic [CNT_W-1:0]  count;
    cnt_evt_t          evt;
    logic [31:0]       ctrl_word;
    logic              wr_ctrl, wr_filt, wr_ceil, wr_stat, wr_mask;
    logic [STAT_W-1:0] st_set, st_clr;

    // ---------------- input conditioning ----------------
    assign raw_pins = {enc_idx, enc_b, enc_a};
    assign flt_on   = regs_q.ctrl.flt_en && (regs_q.filt != '0);

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        qenc_input_cond #(
            .FLT_W      (FLT_W),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (raw_pins[gi]),
            .flt_on (flt_on),
            .flt_len(regs_q.filt),
            .level  (clean[gi])
        );
    end

    assign pol_mask = {regs_q.ctrl.pol_idx, regs_q.ctrl.pol_b, regs_q.ctrl.pol_a};
    assign aligned  = clean ^ ~pol_mask;

    // ---------------- decode and count ----------------
    qenc_step_decode u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .a_in (aligned[IN_A]),
        .b_in (aligned[IN_B]),
        .swap (regs_q.ctrl.swap),
        .a_eff(a_eff),
        .b_eff(b_eff),
        .step (step),
        .up   (up)
    );

    assign gate_ok = ({a_eff, b_eff} == regs_q.ctrl.gate);
    assign idx_hit = regs_q.ctrl.run && !regs_q.ctrl.rst_on_ceil && gate_ok &&
                     aligned[IN_IDX] && !regs_q.idx_prev;

    qenc_position #(.CNT_W(CNT_W)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (regs_q.ctrl.run),
        .step   (step),
        .up     (up),
        .idx_hit(idx_hit),
        .ceil   (regs_q.ceil),
        .count  (count),
        .evt    (evt)
    );

    // ---------------- register file ----------------
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_filt = bus_wr && (bus_addr == ADDR_W'(OFS_FILT));
    assign wr_ceil = bus_wr && (bus_addr == ADDR_W'(OFS_CEIL));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));

    always_comb begin
        regs_d = regs_q;

        if (wr_ctrl) begin
            if (regs_q.ctrl.run) regs_d.ctrl.run = bus_wdata[CB_RUN];
            else                 regs_d.ctrl     = word_to_ctrl(32'(bus_wdata));
        end
        if (wr_filt && !regs_q.ctrl.run) regs_d.filt = bus_wdata[FLT_W-1:0];
        if (wr_ceil && !regs_q.ctrl.run) regs_d.ceil = bus_wdata[CNT_W-1:0];
        if (wr_mask)                     regs_d.mask = bus_wdata[STAT_W-1:0];

        st_set             = '0;
        st_set[ST_WRAP_UP] = evt.up;
        st_set[ST_WRAP_DN] = evt.down;
        st_set[ST_TURN]    = evt.turn;
        st_clr             = wr_stat ? bus_wdata[STAT_W-1:0] : '0;
        regs_d.stat        = (regs_q.stat & ~st_clr) | st_set;

        regs_d.idx_prev = aligned[IN_IDX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.ceil <= '1;
            regs_q.mask <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_word = ctrl_to_word(regs_q.ctrl);

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl_word);
            ADDR_W'(OFS_FILT):  bus_rdata = DATA_W'(regs_q.filt);
            ADDR_W'(OFS_COUNT): bus_rdata = DATA_W'(count);
            ADDR_W'(OFS_CEIL):  bus_rdata = DATA_W'(regs_q.ceil);
            ADDR_W'(OFS_STAT):  bus_rdata = DATA_W'(regs_q.stat);
            ADDR_W'(OFS_MASK):  bus_rdata = DATA_W'(regs_q.mask);
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = |(regs_q.stat & ~regs_q.mask);
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
    parameter int CNT_W  = 32,
    parameter int FLT_W  = 21,
    parameter int ST_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [9:0]       cfg,
    input logic [FLT_W-1:0] filt,
    input logic [CNT_W-1:0] ceil,
    input logic [CNT_W-1:0] count,
    input logic [ST_W-1:0]  stat
);
    // R9: a stopped counter keeps its value
    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));

    // R8: configuration fields frozen while running
    assert_cfg_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cfg));

    assert_limits_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(ceil) && $stable(filt)));

    // R10: no status bit appears while stopped
    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((stat & ~$past(stat)) == '0));

    // R2, R4, R5: count moves by one, wraps, or returns to zero
    assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((count == $past(count)) ||
                 (count == $past(count) + 1'b1) ||
                 (count == $past(count) - 1'b1) ||
                 (count == '0) ||
                 (count == $past(ceil))));
endmodule

bind quad_enc_ctr qenc_checker #(
    .CNT_W(CNT_W),
    .FLT_W(FLT_W),
    .ST_W (qenc_pkg::STAT_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (regs_q.ctrl.run),
    .cfg  (ctrl_word[10:1]),
    .filt (regs_q.filt),
    .ceil (regs_q.ceil),
    .count(count),
    .stat (regs_q.stat)
);

// File: tb/quad_enc_ctr_test.sv
module quad_enc_ctr_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pa, pb, pidx;
    logic        irq;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    int          ph = 0;
    logic [31:0] exp_cnt = 0;

    always #4 clk = ~clk;

    quad_enc_ctr uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(pa), .enc_b(pb), .enc_idx(pidx), .irq(irq)
    );

    localparam logic [7:0] A_CTRL = 8'h00, A_FILT = 8'h04, A_CNT = 8'h08,
                           A_CEIL = 8'h0C, A_STAT = 8'h20, A_MASK = 8'h24;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] cw(bit run, bit flt, bit ea, bit eb, bit ei,
                                       bit swp, bit mode, logic [1:0] gate);
        return {21'd0, gate, mode, 2'b00, swp, ei, eb, ea, flt, run};
    endfunction

    function automatic logic [31:0] nxt(logic [31:0] c, bit upd, logic [31:0] lim);
        if (upd) return (c == lim) ? 32'd0 : c + 1;
        return (c == 0) ? lim : c - 1;
    endfunction

    // physical phase order 00,10,11,01 as {A,B}
    task automatic put_ph(input int p, input int hold);
        ph = p & 3;
        pa = (ph == 1 || ph == 2);
        pb = (ph == 2 || ph == 3);
        idle(hold);
    endtask

    task automatic fwd(input int n, input int hold);
        for (int i = 0; i < n; i++) put_ph(ph + 1, hold);
    endtask

    task automatic back(input int n, input int hold);
        for (int i = 0; i < n; i++) put_ph(ph + 3, hold);
    endtask

    task automatic configure(input logic [31:0] w);
        wr(A_CTRL, w & ~32'd1);
        idle(12);
        wr(A_CTRL, w | 32'd1);
        idle(4);
    endtask

    task automatic pulse_idx();
        pidx = 1'b1; idle(8);
        pidx = 1'b0; idle(8);
    endtask

    // index reset with gate 0 at pins 00
    task automatic zero_count();
        wr(A_CTRL, 0);
        put_ph(0, 12);
        configure(cw(0, 0, 1, 1, 1, 0, 0, 2'd0));
        pulse_idx();
        wr(A_CTRL, 0);
        idle(4);
        exp_cnt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lims [2];
        bit upd;
        lims[0] = 32'd3; lims[1] = 32'd6;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pa = 1'b0; pb = 1'b0; pidx = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 control", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_FILT, v); chk("R1 filter", v, 0);
        rd(A_CEIL, v); chk("R1 ceiling", v, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_MASK, v); chk("R1 mask", v, 32'h3F);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 R3 R4 sweep over ceiling, swap and both phase polarities
        for (int li = 0; li < 2; li++) begin
            for (int cfgi = 0; cfgi < 8; cfgi++) begin
                bit swp, ea, eb;
                swp = cfgi[2]; ea = cfgi[1]; eb = cfgi[0];
                zero_count();
                wr(A_CEIL, lims[li]);
                configure(cw(0, 0, ea, eb, 1, swp, 1, 2'd0));
                upd = !(swp ^ ea ^ eb);
                for (int s = 0; s < 9; s++) begin
                    fwd(1, 8);
                    exp_cnt = nxt(exp_cnt, upd, lims[li]);
                end
                rd(A_CNT, v); chk("R2 R3 R4 sweep forward", v, exp_cnt);
                for (int s = 0; s < 5; s++) begin
                    back(1, 8);
                    exp_cnt = nxt(exp_cnt, !upd, lims[li]);
                end
                rd(A_CNT, v); chk("R2 R3 R4 sweep reverse", v, exp_cnt);
            end
        end

        // R11 unused status bits never set; clear all
        rd(A_STAT, v); chk("R11 unused status bits", v & 32'h31, 0);
        wr(A_STAT, 32'h3F);
        rd(A_STAT, v); chk("R11 write-one clear", v, 0);

        // R4 R10 R11 wraps, direction change, interrupt
        zero_count();
        wr(A_CEIL, 32'd3);
        configure(cw(0, 0, 1, 1, 1, 0, 1, 2'd0));
        fwd(3, 8);
        wr(A_STAT, 32'h3F);
        fwd(1, 8);
        rd(A_CNT, v);  chk("R4 wrap up to zero", v, 0);
        rd(A_STAT, v); chk("R4 up-wrap status", v, 32'h04);
        chk("R11 irq masked", {31'd0, irq}, 0);
        wr(A_MASK, 32'h3B);
        idle(1);
        chk("R11 irq unmasked", {31'd0, irq}, 1);
        wr(A_STAT, 32'h04);
        rd(A_STAT, v); chk("R11 clear bit2", v, 0);
        chk("R11 irq after clear", {31'd0, irq}, 0);
        back(1, 8);
        rd(A_CNT, v);  chk("R4 wrap down to ceiling", v, 3);
        rd(A_STAT, v); chk("R10 R4 down-wrap and turn", v, 32'h0A);
        chk("R11 irq with bits masked", {31'd0, irq}, 0);
        wr(A_MASK, 32'h37);
        idle(1);
        chk("R11 irq on turn bit", {31'd0, irq}, 1);

        // R8 R9 writes while running
        wr(A_CEIL, 32'd9);
        rd(A_CEIL, v); chk("R8 ceiling locked", v, 3);
        wr(A_FILT, 32'd5);
        rd(A_FILT, v); chk("R8 filter locked", v, 0);
        wr(A_CTRL, cw(1, 0, 1, 1, 1, 1, 1, 2'd0));
        rd(A_CTRL, v); chk("R8 control fields locked", v, cw(1, 0, 1, 1, 1, 0, 1, 2'd0));
        wr(A_CNT, 32'h55);
        rd(A_CNT, v);  chk("R9 count read-only", v, 3);
        wr(A_CTRL, 0);
        rd(A_CTRL, v); chk("R8 run bit writable", v, cw(0, 0, 1, 1, 1, 0, 1, 2'd0));
        fwd(2, 8);
        rd(A_CNT, v);  chk("R9 hold while stopped", v, 3);

        // R5 gated index reset
        zero_count();
        configure(cw(0, 0, 1, 1, 1, 0, 0, 2'd1));
        fwd(2, 8);
        pulse_idx();
        rd(A_CNT, v);  chk("R5 gate mismatch ignored", v, 2);
        wr(A_CTRL, 0);
        configure(cw(0, 0, 1, 1, 1, 0, 0, 2'd3));
        wr(A_STAT, 32'h3F);
        pulse_idx();
        rd(A_CNT, v);  chk("R5 gated reset", v, 0);
        rd(A_STAT, v); chk("R5 reset status up", v, 32'h04);
        fwd(1, 8);
        wr(A_CTRL, 0);
        configure(cw(0, 0, 1, 1, 0, 0, 0, 2'd1));
        pidx = 1'b1; idle(8);
        rd(A_CNT, v);  chk("R5 falling select ignores rise", v, 1);
        pidx = 1'b0; idle(8);
        rd(A_CNT, v);  chk("R5 falling edge resets", v, 0);

        // R6 index ignored in wrap mode
        fwd(2, 8);
        wr(A_CTRL, 0);
        configure(cw(0, 0, 1, 1, 1, 0, 1, 2'd2));
        pulse_idx();
        rd(A_CNT, v);  chk("R6 index ignored", v, 2);

        // R7 filter
        wr(A_CTRL, 0);
        wr(A_FILT, 32'd5);
        rd(A_FILT, v); chk("R7 filter length", v, 5);
        configure(cw(0, 1, 1, 1, 1, 0, 1, 2'd0));
        pb = 1'b1; idle(3);
        pb = 1'b0; idle(14);
        rd(A_CNT, v);  chk("R7 short pulse dropped", v, 2);
        put_ph(2, 16);
        rd(A_CNT, v);  chk("R7 long level accepted", v, 3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule